// File: doc/BRIEF.md
# Scaled Add and Field Extract Unit

This block is a small integer execution slice for address arithmetic and bit-field work. Each cycle it can accept one operation: a plain two-operand add, an add of a sign-extended 8-bit immediate, an add of a sign-extended 8-bit immediate moved up into the second byte, a scaled-index add that multiplies the first operand by 2, 4 or 8 before adding the second (the usual table-indexing step), or an unsigned field extract that shifts the first operand right and keeps a chosen number of low bits.

The result is captured in a register one clock after a request marked valid. A two-state controller tracks whether the register holds a fresh result. In state `RES_EMPTY` no new result is present. In state `RES_FULL` the result was captured on the last edge. The transition `ACCEPT` (in_valid high) leads from either state to `RES_FULL`. The transition `IDLE` (in_valid low) leads from either state to `RES_EMPTY`. `out_valid` is high exactly in `RES_FULL`. All sums wrap modulo 2^32 and no overflow is reported.

Top module: `sax_unit`

## Requirements
- R1: While rst_n is low and on the first cycle after its release, out_valid is 0 and result is 0.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 in the cycle after a cycle with in_valid low.
- R3: When in_valid is low, result keeps its previous value whatever the other inputs do.
- R4: op=0 (plain add) yields src_a + src_b modulo 2^32.
- R5: op=1 (immediate add) yields src_a plus imm8 sign-extended to 32 bits, modulo 2^32.
- R6: op=2 (upper immediate add) yields src_a plus imm8 sign-extended and multiplied by 256, so the added value lies from -32768 to 32512 in steps of 256.
- R7: op=3, 4 and 5 yield (src_a shifted left by 1, 2 and 3 respectively, bits above 31 dropped) + src_b modulo 2^32.
- R8: op=6 (field extract) yields (src_a >> shamt) AND a mask of w ones, where w = fwidth + 1, so fwidth codes 0 to 15 give widths 1 to 16 and shamt ranges 0 to 31.
- R9: op=7 yields a result of 0.
- R10: Fields an operation does not use have no effect: shamt and fwidth for ops 0 to 5, imm8 for ops 0 and 3 to 6, src_b for ops 1, 2 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code (0 to 7) |
| src_a | input | 32 | First operand (scaled or extracted operand) |
| src_b | input | 32 | Second operand |
| shamt | input | 5 | Right shift amount for field extract |
| fwidth | input | 4 | Field width minus one for field extract |
| imm8 | input | 8 | Signed immediate |
| out_valid | output | 1 | Result captured from a request on the previous edge |
| result | output | 32 | Registered result |

## Verification
Every operation has a latency of one cycle: a request driven on a falling edge is captured on the next rising edge, and both out_valid and result are due at the falling edge after that. The bench drives stimulus only on falling edges and compares outputs on the following falling edge against its own model, so every check lands exactly one register stage after its stimulus. Hold behaviour is checked the same way, one falling edge after in_valid drops, with fresh values on the unused inputs.

// File: rtl/sax_pkg.sv
package sax_pkg;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_ADDI   = 3'd1,
        OP_ADDHI  = 3'd2,
        OP_ADDX2  = 3'd3,
        OP_ADDX4  = 3'd4,
        OP_ADDX8  = 3'd5,
        OP_EXTRACT = 3'd6,
        OP_RSVD   = 3'd7
    } sax_op_e;

    typedef enum logic {
        RES_EMPTY = 1'b0,
        RES_FULL  = 1'b1
    } sax_state_e;

endpackage

// File: rtl/sax_add_path.sv
module sax_add_path
    import sax_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 8,
    parameter int HI_SHIFT  = 8,
    parameter int MAX_SCALE = 3
) (
    input  sax_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] sum_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_hi;
    logic [DATA_W-1:0] scaled [0:MAX_SCALE];
    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;

    assign imm_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign imm_hi   = imm_sext << HI_SHIFT;

    // one shifted copy of the first operand per scale step
    for (genvar k = 0; k <= MAX_SCALE; k++) begin : g_scale
        assign scaled[k] = a_i << k;
    end

    always_comb begin
        lhs = a_i;
        rhs = '0;
        unique case (op_i)
            OP_ADD:   begin lhs = scaled[0]; rhs = b_i;      end
            OP_ADDI:  begin lhs = scaled[0]; rhs = imm_sext; end
            OP_ADDHI: begin lhs = scaled[0]; rhs = imm_hi;   end
            OP_ADDX2: begin lhs = scaled[1]; rhs = b_i;      end
            OP_ADDX4: begin lhs = scaled[2]; rhs = b_i;      end
            OP_ADDX8: begin lhs = scaled[MAX_SCALE]; rhs = b_i; end
            default:  begin lhs = '0;        rhs = '0;       end
        endcase
    end

    assign sum_o = lhs + rhs;

endmodule

// File: rtl/sax_field_extract.sv
module sax_field_extract #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5,
    parameter int FW_W    = 4
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [FW_W-1:0]    fwidth_i,
    output logic [DATA_W-1:0]  field_o
);
    localparam int CNT_W = FW_W + 1;

    logic [CNT_W-1:0]  width_bits;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] shifted;

    assign width_bits = {1'b0, fwidth_i} + CNT_W'(1);
    assign mask       = (DATA_W'(1) << width_bits) - DATA_W'(1);
    assign shifted    = a_i >> shamt_i;
    assign field_o    = shifted & mask;

endmodule

// File: rtl/sax_unit.sv
module sax_unit
    import sax_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 8,
    parameter int SHAMT_W  = 5,
    parameter int FW_W     = 4,
    parameter int HI_SHIFT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         op,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [FW_W-1:0]    fwidth,
    input  logic [IMM_W-1:0]   imm8,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result
);
    localparam int MAX_SCALE = 3;

    sax_op_e           op_e;
    sax_state_e        state_q, state_d;
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] field_w;
    logic [DATA_W-1:0] result_d;

    assign op_e = sax_op_e'(op);

    sax_add_path #(
        .DATA_W(DATA_W), .IMM_W(IMM_W), .HI_SHIFT(HI_SHIFT), .MAX_SCALE(MAX_SCALE)
    ) u_add (
        .op_i(op_e), .a_i(src_a), .b_i(src_b), .imm_i(imm8), .sum_o(sum_w)
    );

    sax_field_extract #(
        .DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .FW_W(FW_W)
    ) u_ext (
        .a_i(src_a), .shamt_i(shamt), .fwidth_i(fwidth), .field_o(field_w)
    );

    always_comb begin
        unique case (op_e)
            OP_EXTRACT: result_d = field_w;
            OP_RSVD:    result_d = '0;
            default:    result_d = sum_w;
        endcase
    end

    // next state: ACCEPT or IDLE
    always_comb begin
        unique case (state_q)
            RES_EMPTY: state_d = in_valid ? RES_FULL : RES_EMPTY;
            RES_FULL:  state_d = in_valid ? RES_FULL : RES_EMPTY;
            default:   state_d = RES_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RES_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= result_d;
    end

    assign out_valid = (state_q == RES_FULL);

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R3
    AST_FIELD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd6) |=> ((result >> ({2'b00, $past(fwidth)} + 6'd1)) == '0)); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd7) |=> (result == '0)); // R9

endmodule

// File: tb/tb_sax_unit.sv
module tb_sax_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [4:0]  shamt = '0;
    logic [3:0]  fwidth = '0;
    logic [7:0]  imm8 = '0;
    logic        out_valid;
    logic [31:0] result;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    sax_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .shamt(shamt), .fwidth(fwidth),
        .imm8(imm8), .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a,
            input logic [31:0] b, input logic [4:0] s, input logic [3:0] w,
            input logic [7:0] i);
        logic [31:0] se;
        logic [63:0] m;
        se = {{24{i[7]}}, i};
        m  = (64'd1 << (w + 1)) - 64'd1;
        case (o)
            3'd0: return a + b;
            3'd1: return a + se;
            3'd2: return a + (se * 32'd256);
            3'd3: return (a * 32'd2) + b;
            3'd4: return (a * 32'd4) + b;
            3'd5: return (a * 32'd8) + b;
            3'd6: return (a >> s) & m[31:0];
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [2:0] o, input logic [31:0] a,
            input logic [31:0] b, input logic [4:0] s, input logic [3:0] w, input logic [7:0] i);
        in_valid = 1'b1; op = o; src_a = a; src_b = b; shamt = s; fwidth = w; imm8 = i;
        @(negedge clk);
        check({req, " R2 valid"}, {31'd0, out_valid}, 32'd1);
        check(req, result, model(o, a, b, s, w, i));
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'h5A1D_0C3E));
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1 result in reset", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 result after reset", result, 32'd0);

        apply("R4 add wrap", 3'd0, 32'hFFFF_FFFF, 32'd2, 5'd0, 4'd0, 8'd0);
        apply("R5 addi neg", 3'd1, 32'd10, 32'd0, 5'd0, 4'd0, 8'h80);
        apply("R5 addi pos", 3'd1, 32'd10, 32'hDEAD, 5'd3, 4'd2, 8'h7F);
        apply("R6 addhi min", 3'd2, 32'h0001_0000, 32'd5, 5'd0, 4'd0, 8'h80);
        apply("R6 addhi max", 3'd2, 32'h0, 32'd5, 5'd0, 4'd0, 8'h7F);
        apply("R7 x2", 3'd3, 32'h8000_0001, 32'd1, 5'd0, 4'd0, 8'd0);
        apply("R7 x4", 3'd4, 32'h4000_0003, 32'h10, 5'd0, 4'd0, 8'd0);
        apply("R7 x8", 3'd5, 32'hF000_0001, 32'hFFFF_FFFF, 5'd0, 4'd0, 8'd0);
        apply("R8 shift16 w3", 3'd6, 32'h00AB_CDEF, 32'd0, 5'd16, 4'd2, 8'd0);
        apply("R8 w16 shift0", 3'd6, 32'hFFFF_FFFF, 32'd0, 5'd0, 4'd15, 8'd0);
        apply("R8 w1 shift31", 3'd6, 32'h8000_0000, 32'd0, 5'd31, 4'd0, 8'd0);
        apply("R9 reserved", 3'd7, 32'h1234_5678, 32'h1, 5'd1, 4'd1, 8'h11);
        // R10: same operands with different unused fields must give same result
        apply("R10 add unused A", 3'd0, 32'h100, 32'h23, 5'd0, 4'd0, 8'h00);
        apply("R10 add unused B", 3'd0, 32'h100, 32'h23, 5'd31, 4'd15, 8'hFF);
        check("R10 add unused same", result, 32'h123);
        apply("R10 extract ignores b,imm", 3'd6, 32'hF0, 32'hFFFF, 5'd4, 4'd3, 8'hAA);
        check("R10 extract value", result, 32'hF);

        // R3 hold with changing inputs
        held = result;
        in_valid = 1'b0; op = 3'd0; src_a = 32'h5555; src_b = 32'h7777; imm8 = 8'h3C;
        @(negedge clk);
        check("R2 valid drops", {31'd0, out_valid}, 32'd0);
        check("R3 hold", result, held);
        src_a = 32'h1; op = 3'd6;
        @(negedge clk);
        check("R3 hold 2", result, held);

        for (int n = 0; n < 400; n++) begin
            logic [2:0] ro;
            ro = 3'($urandom_range(0, 7));
            apply("R4-R9 random", ro, $urandom, $urandom, 5'($urandom), 4'($urandom), 8'($urandom));
            if (($urandom & 3) == 0) begin
                held = result;
                in_valid = 1'b0; src_a = $urandom; imm8 = 8'($urandom);
                @(negedge clk);
                check("R3 random hold", result, held);
                check("R2 random idle", {31'd0, out_valid}, 32'd0);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule